// File: doc/BRIEF.md
# Power-on self-test sequencer

This block brings a crypto accelerator out of reset. Its first step clears the shared working RAM by writing zero to every address. It then waits for an outside verdict on the loaded firmware image. A good verdict makes it start a known-answer test on each algorithm engine, one engine at a time and always in the same order. Each verdict is stored as its own bit in a status register.

When every engine passes, the block opens the data path and accepts all control requests. When any engine fails or times out, it goes to a crypto-disabled state. In that state no data leaves the block, and only status-query control requests are still taken. A bad firmware verdict leaves the block uninitialized: nothing runs until an outside management agent pulses a re-initialize strobe. Asserting reset clears the results and runs the whole sequence again.

The engine index order is fixed: 0 AES-GCM-256, 1 AES-CTR-256, 2 AES-XTS-256, 3 HMAC-SHA-1, 4 HMAC-SHA2-256, 5 HMAC-SHA2-512, 6 HMAC-SHA3-256, 7 HMAC-SHA3-512.

Top module: `selftest_seq`

## Requirements
- R1: During reset, and for RAM_DEPTH cycles after reset is released, `zero_we` is 1. `zero_addr` steps 0, 1, ..., RAM_DEPTH-1, one address per cycle, and `zero_we` then drops to 0. While `zero_we` is 1, no test starts and `data_out_en` is 0.
- R2: Once the sweep ends, the block waits in state code 1 for `fw_ok_valid`. A strobe that arrives during reset or during the sweep is ignored.
- R3: A strobe with `fw_ok`=0 moves the block to state code 5. In that state no test starts, `data_out_en` is 0 and no control request is accepted. A one-cycle `reinit` pulse returns the block to state code 1.
- R4: A strobe with `fw_ok`=1 starts the tests (state code 2). Each engine gets a one-cycle pulse on its own `kat_start` bit. Engines run one at a time in index order 0 to NUM_ENG-1, and the next start is issued only after the current engine has finished.
- R5: An engine finishes when it raises its `kat_done` bit. The value of its `kat_fail` bit in that cycle is stored as status bit i, where 1 means failed. A status bit keeps its value until reset.
- R6: If an engine does not raise `kat_done` within KAT_TIMEOUT cycles after its start pulse, its status bit is set to 1 and the sequence moves on to the next engine.
- R7: If all engines pass, the block enters state code 3. There `data_out_en` is 1 and `ctrl_accept` follows `ctrl_req` for every `ctrl_type`.
- R8: If any status bit is 1 after the last engine, the block enters state code 4. There `data_out_en` is 0 and only `ctrl_type`=0 (status query) is accepted.
- R9: When `stat_rd_en` is 1 in a cycle, `stat_rd_data` shows {state code[2:0], status bits[NUM_ENG-1:0]} from the next cycle on.
- R10: Asserting reset from any state clears every status bit, then repeats the sweep and the whole test sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fw_ok_valid | input | 1 | Firmware verdict strobe |
| fw_ok | input | 1 | Firmware verdict, 1 = good |
| reinit | input | 1 | Re-initialize pulse from the management agent |
| kat_start | output | NUM_ENG | Per-engine test start pulse |
| kat_done | input | NUM_ENG | Per-engine test finished |
| kat_fail | input | NUM_ENG | Per-engine test failed, valid with done |
| stat_rd_en | input | 1 | Status read request |
| stat_rd_data | output | NUM_ENG+3 | {state code, status bits} |
| data_out_en | output | 1 | Data output permitted |
| ctrl_req | input | 1 | Control request |
| ctrl_type | input | 2 | Control request kind, 0 = status query |
| ctrl_accept | output | 1 | Control request taken |
| zero_we | output | 1 | Shared-RAM zero write enable |
| zero_addr | output | clog2(RAM_DEPTH) | Shared-RAM zero write address |

## Verification
The assertions assume that an engine raises `kat_done` only after its own start pulse, and that `kat_fail` is valid in the same cycle. The bench models each engine as a responder with a programmed latency and verdict, driven on the falling edge, so this assumption always holds. A latency of zero models an engine that never answers, which exercises the timeout. Firmware strobes, re-initialize pulses and control requests are applied one cycle at a time between edges, sometimes on purpose in states where they must have no effect.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  typedef enum logic [2:0] {
    ST_ZERO   = 3'd0,
    ST_WAITFW = 3'd1,
    ST_RUN    = 3'd2,
    ST_OPER   = 3'd3,
    ST_DIS    = 3'd4,
    ST_UNINIT = 3'd5
  } st_e;

  localparam logic [1:0] CTRL_STATUS_Q = 2'd0;

  // control requests allowed in each state
  function automatic logic ctrl_allowed(st_e s, logic [1:0] kind);
    case (s)
      ST_OPER: return 1'b1;
      ST_DIS:  return kind == CTRL_STATUS_Q;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/zero_sweep.sv
module zero_sweep #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [AW-1:0] addr,
  output logic          last
);
  assign last = addr == AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr <= '0;
    else if (en) addr <= last ? '0 : addr + 1'b1;
  end
endmodule

// File: rtl/kat_timer.sv
module kat_timer #(
  parameter int LIMIT = 20,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [TW-1:0] cnt;

  assign expired = cnt == TW'(LIMIT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run)            cnt <= '0;
    else if (!expired)        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/kat_status.sv
module kat_status #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic [N-1:0] sel,
  input  logic         fail_in,
  output logic [N-1:0] bits
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 bits[i] <= 1'b0;
      else if (commit && sel[i])  bits[i] <= fail_in;
    end
  end
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int NUM_ENG     = 8,
  parameter int RAM_DEPTH   = 16,
  parameter int KAT_TIMEOUT = 20,
  localparam int IW = $clog2(NUM_ENG),
  localparam int AW = $clog2(RAM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fw_ok_valid,
  input  logic               fw_ok,
  input  logic               reinit,
  output logic [NUM_ENG-1:0] kat_start,
  input  logic [NUM_ENG-1:0] kat_done,
  input  logic [NUM_ENG-1:0] kat_fail,
  input  logic               stat_rd_en,
  output logic [NUM_ENG+2:0] stat_rd_data,
  output logic               data_out_en,
  input  logic               ctrl_req,
  input  logic [1:0]         ctrl_type,
  output logic               ctrl_accept,
  output logic               zero_we,
  output logic [AW-1:0]      zero_addr
);
  st_e              state, state_n;
  logic [IW-1:0]    idx;
  logic             launch;
  logic [NUM_ENG-1:0] eng_sel, fail_q;

  // named internal events
  logic in_wait, done_sel, timer_expired, kat_timeout, kat_commit;
  logic commit_fail, last_eng, sweep_last, any_fail_next;
  logic [2:0] st_code;

  assign st_code       = state;
  assign eng_sel       = NUM_ENG'(1) << idx;
  assign in_wait       = (state == ST_RUN) && !launch;
  assign done_sel      = in_wait && kat_done[idx];
  assign kat_timeout   = in_wait && timer_expired && !done_sel;
  assign kat_commit    = done_sel || kat_timeout;
  assign commit_fail   = done_sel ? kat_fail[idx] : 1'b1;
  assign last_eng      = idx == IW'(NUM_ENG - 1);
  assign any_fail_next = (|fail_q) || (kat_commit && commit_fail);

  zero_sweep #(.DEPTH(RAM_DEPTH)) u_sweep (
    .clk(clk), .rst_n(rst_n), .en(state == ST_ZERO),
    .addr(zero_addr), .last(sweep_last)
  );

  kat_timer #(.LIMIT(KAT_TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_wait), .expired(timer_expired)
  );

  kat_status #(.N(NUM_ENG)) u_status (
    .clk(clk), .rst_n(rst_n), .commit(kat_commit), .sel(eng_sel),
    .fail_in(commit_fail), .bits(fail_q)
  );

  always_comb begin
    state_n = state;
    case (state)
      ST_ZERO:   if (sweep_last) state_n = ST_WAITFW;
      ST_WAITFW: if (fw_ok_valid) state_n = fw_ok ? ST_RUN : ST_UNINIT;
      ST_RUN:    if (kat_commit && last_eng)
                   state_n = any_fail_next ? ST_DIS : ST_OPER;
      ST_UNINIT: if (reinit) state_n = ST_WAITFW;
      default:   state_n = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_ZERO;
      idx    <= '0;
      launch <= 1'b0;
    end else begin
      state <= state_n;
      if (state == ST_WAITFW && fw_ok_valid && fw_ok) begin
        idx    <= '0;
        launch <= 1'b1;
      end else if (state == ST_RUN) begin
        if (launch) launch <= 1'b0;
        else if (kat_commit && !last_eng) begin
          idx    <= idx + 1'b1;
          launch <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stat_rd_data <= '0;
    else if (stat_rd_en) stat_rd_data <= {st_code, fail_q};
  end

  assign kat_start   = (state == ST_RUN && launch) ? eng_sel : '0;
  assign data_out_en = state == ST_OPER;
  assign ctrl_accept = ctrl_req && ctrl_allowed(state, ctrl_type);
  assign zero_we     = state == ST_ZERO;
endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk #(
  parameter int NUM_ENG = 8,
  localparam int IW = $clog2(NUM_ENG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_ENG-1:0] kat_start,
  input logic               data_out_en,
  input logic               zero_we,
  input logic               ctrl_accept,
  input logic [1:0]         ctrl_type,
  input logic [2:0]         st_code,
  input logic [NUM_ENG-1:0] fail_q,
  input logic [IW-1:0]      idx,
  input logic               kat_timeout
);
  logic [NUM_ENG-1:0] cur_oh;
  assign cur_oh = NUM_ENG'(1) << idx;

  assert_start_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kat_start));

  assert_sweep_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    zero_we |-> (kat_start == '0 && !data_out_en));

  assert_dout_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_out_en |-> (fail_q == '0 && st_code == 3'd3));

  assert_limited_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 3'd4 && ctrl_accept) |-> ctrl_type == 2'd0);

  assert_uninit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 3'd5) |-> (!ctrl_accept && kat_start == '0 && !data_out_en));

  assert_sticky_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q != '0) |=> ((fail_q & $past(fail_q)) == $past(fail_q)));

  assert_timeout_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kat_timeout |=> ((fail_q & $past(cur_oh)) != '0));
endmodule

bind selftest_seq selftest_seq_chk #(.NUM_ENG(NUM_ENG)) u_chk (
  .clk(clk), .rst_n(rst_n), .kat_start(kat_start), .data_out_en(data_out_en),
  .zero_we(zero_we), .ctrl_accept(ctrl_accept), .ctrl_type(ctrl_type),
  .st_code(st_code), .fail_q(fail_q), .idx(idx), .kat_timeout(kat_timeout)
);

// File: tb/selftest_seq_bench.sv
module selftest_seq_bench;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int DEPTH = 16;
  localparam int TMO   = 20;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fw_ok_valid = 1'b0, fw_ok = 1'b0, reinit = 1'b0;
  logic [N-1:0] kat_start, kat_done, kat_fail;
  logic stat_rd_en = 1'b0;
  logic [N+2:0] stat_rd_data;
  logic data_out_en, ctrl_req = 1'b0, ctrl_accept, zero_we;
  logic [1:0] ctrl_type = 2'd0;
  logic [AW-1:0] zero_addr;

  int total = 0, bad = 0;
  int lat [N];
  bit vfail [N];
  int cnt [N];
  int order [64];
  int nstart = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  selftest_seq #(.NUM_ENG(N), .RAM_DEPTH(DEPTH), .KAT_TIMEOUT(TMO)) u_selftest_seq (
    .clk(clk), .rst_n(rst_n), .fw_ok_valid(fw_ok_valid), .fw_ok(fw_ok),
    .reinit(reinit), .kat_start(kat_start), .kat_done(kat_done),
    .kat_fail(kat_fail), .stat_rd_en(stat_rd_en), .stat_rd_data(stat_rd_data),
    .data_out_en(data_out_en), .ctrl_req(ctrl_req), .ctrl_type(ctrl_type),
    .ctrl_accept(ctrl_accept), .zero_we(zero_we), .zero_addr(zero_addr)
  );

  // engine responders: latency 0 means the engine never answers
  initial begin
    kat_done = '0;
    kat_fail = '0;
    for (int i = 0; i < N; i++) cnt[i] = 0;
  end

  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      kat_done[i] = 1'b0;
      kat_fail[i] = 1'b0;
      if (kat_start[i]) begin
        cnt[i] = lat[i];
        order[nstart % 64] = i;
        nstart++;
      end else if (cnt[i] != 0) begin
        cnt[i]--;
        if (cnt[i] == 0) begin
          kat_done[i] = 1'b1;
          kat_fail[i] = vfail[i];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_engines(input int l, input int fail_idx, input int hang_idx);
    for (int i = 0; i < N; i++) begin
      lat[i]   = (i == hang_idx) ? 0 : l + i;
      vfail[i] = (i == fail_idx);
    end
  endtask

  task automatic read_stat(output logic [N+2:0] v);
    @(negedge clk) stat_rd_en = 1'b1;
    @(negedge clk) stat_rd_en = 1'b0;
    v = stat_rd_data;
  endtask

  // reset plus sweep check (R1, R10)
  task automatic do_reset(input bit strobe_during);
    int writes = 0;
    int addr_bad = 0;
    @(negedge clk) rst_n = 1'b0;
    fw_ok_valid = strobe_during;
    fw_ok = 1'b0;
    for (int i = 0; i < N; i++) cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      if (k > 0) @(negedge clk);
      if (zero_we) writes++;
      if (int'(zero_addr) != k) addr_bad++;
      if (kat_start != '0 || data_out_en) addr_bad++;
    end
    @(negedge clk);
    fw_ok_valid = 1'b0;
    chk(writes == DEPTH, "R1 sweep write count", writes, DEPTH);
    chk(addr_bad == 0, "R1 sweep address order", addr_bad, 0);
    chk(!zero_we, "R1 sweep ends", zero_we, 0);
  endtask

  task automatic give_fw(input bit ok);
    @(negedge clk) begin fw_ok_valid = 1'b1; fw_ok = ok; end
    @(negedge clk) fw_ok_valid = 1'b0;
  endtask

  task automatic wait_end(output logic [N+2:0] v);
    read_stat(v);
    for (int g = 0; g < 400 && v[N+2:N] == 3'd2; g++) read_stat(v);
  endtask

  task automatic try_ctrl(input logic [1:0] t, output logic acc);
    @(negedge clk) begin ctrl_req = 1'b1; ctrl_type = t; end
    #1 acc = ctrl_accept;
    @(negedge clk) ctrl_req = 1'b0;
  endtask

  task automatic t_all_pass();
    logic [N+2:0] v;
    logic a;
    int ord_bad = 0;
    set_engines(2, -1, -1);
    do_reset(1'b0);
    nstart = 0;
    give_fw(1'b1);
    wait_end(v);
    chk(v[N+2:N] == 3'd3, "R7 operational code", v[N+2:N], 3);
    chk(v[N-1:0] == '0, "R5 all pass bits", v[N-1:0], 0);
    chk(data_out_en, "R7 data out on", data_out_en, 1);
    chk(nstart == N, "R4 start count", nstart, N);
    for (int k = 0; k < N; k++) if (order[k] != k) ord_bad++;
    chk(ord_bad == 0, "R4 start order", ord_bad, 0);
    try_ctrl(2'd2, a);
    chk(a, "R7 any ctrl accepted", a, 1);
  endtask

  task automatic t_one_fail();
    logic [N+2:0] v;
    logic a;
    set_engines(1, 3, -1);
    do_reset(1'b0);
    nstart = 0;
    give_fw(1'b1);
    wait_end(v);
    chk(v[N+2:N] == 3'd4, "R8 disabled code", v[N+2:N], 4);
    chk(v[N-1:0] == N'(8), "R5 fail bit 3", v[N-1:0], 8);
    chk(!data_out_en, "R8 data out off", data_out_en, 0);
    chk(nstart == N, "R4 later engines still run", nstart, N);
    try_ctrl(2'd0, a);
    chk(a, "R8 status query accepted", a, 1);
    try_ctrl(2'd1, a);
    chk(!a, "R8 other ctrl rejected", a, 0);
    read_stat(v);
    chk(v[N-1:0] == N'(8), "R5 bits persist", v[N-1:0], 8);
  endtask

  task automatic t_timeout();
    logic [N+2:0] v;
    set_engines(1, -1, 5);
    lat[2] = TMO;  // answers in the last allowed cycle
    do_reset(1'b0);
    give_fw(1'b1);
    wait_end(v);
    chk(v[N-1:0] == N'(32), "R6 timeout marks engine 5 only", v[N-1:0], 32);
    chk(v[N+2:N] == 3'd4, "R6 timeout leads to disabled", v[N+2:N], 4);
  endtask

  task automatic t_fw_bad();
    logic [N+2:0] v;
    logic a;
    set_engines(1, -1, -1);
    do_reset(1'b0);
    nstart = 0;
    give_fw(1'b0);
    repeat (5) @(negedge clk);
    read_stat(v);
    chk(v[N+2:N] == 3'd5, "R3 uninit code", v[N+2:N], 5);
    chk(nstart == 0, "R3 no tests", nstart, 0);
    chk(!data_out_en, "R3 data out off", data_out_en, 0);
    try_ctrl(2'd0, a);
    chk(!a, "R3 ctrl rejected", a, 0);
    @(negedge clk) reinit = 1'b1;
    @(negedge clk) reinit = 1'b0;
    read_stat(v);
    chk(v[N+2:N] == 3'd1, "R3 reinit to wait", v[N+2:N], 1);
    give_fw(1'b1);
    wait_end(v);
    chk(v[N+2:N] == 3'd3, "R3 pass after reinit", v[N+2:N], 3);
  endtask

  task automatic t_early_strobe();
    logic [N+2:0] v;
    set_engines(1, 0, -1);
    give_fw(1'b1);  // from operational/disabled: no effect wanted
    nstart = 0;
    do_reset(1'b1);
    repeat (3) @(negedge clk);
    read_stat(v);
    chk(v[N+2:N] == 3'd1, "R2 early strobe ignored", v[N+2:N], 1);
    chk(nstart == 0, "R2 no tests yet", nstart, 0);
    chk(v[N-1:0] == '0, "R10 reset clears bits", v[N-1:0], 0);
    give_fw(1'b1);
    wait_end(v);
    chk(v[N-1:0] == N'(1), "R10 rerun records fail", v[N-1:0], 1);
  endtask

  initial begin
    logic [N+2:0] v;
    for (int i = 0; i < N; i++) begin lat[i] = 1; vfail[i] = 0; end
    #1;
    chk(zero_we && !data_out_en && kat_start == '0, "R1 reset state", zero_we, 1);
    read_stat(v);
    chk(v == '0, "R9 read during reset", v, 0);
    t_all_pass();
    t_one_fail();
    t_timeout();
    t_fw_bad();
    t_early_strobe();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule